// File: doc/BRIEF.md
# Configuration Reset Handshake Sequencer

This block models the logic-fabric side of the handshake that software uses to clear and reload a programmable fabric. A program bit in the control register is active low. While it is low, the block clears its configuration state. INIT is a status flag that follows the program bit. It does not follow at once: it takes a rise latency and a fall latency, each set by a parameter in clock cycles. Software starts a full reload by walking the flag through a high, low, high cycle. It sets the program bit and waits for INIT high. It clears the program bit and waits for INIT low. It sets the program bit again and waits for INIT high.

The block accepts configuration words only under these conditions: INIT is high, the program bit is high, the configuration port is enabled, partial reconfiguration routing is selected, and internal loopback is off. It counts the words up to a fixed image length. A slow-rate control bit spaces accepted words apart, which leaves time for decryption on the fly. After a full image has arrived, software hands the port back by clearing the routing bit. Only then does the block raise its done flag and its completion interrupt bit. Pulling the program bit low at any time aborts the load.

Top module: `cfgrst_seq`

## Requirements
- R1: After reset, every control, misc, status and interrupt bit reads 0, except that control bit 7 mirrors `secureBoot`. `wordReady` is 0.
- R2: Control bit 30 is the program bit. When it becomes 1, status bit 4 (INIT) rises exactly INIT_HI_DLY cycles after the new control value is readable.
- R3: When control bit 30 becomes 0, INIT falls exactly INIT_LO_DLY cycles later. If the program bit returns to the INIT value before that latency has elapsed, INIT does not change.
- R4: Only control bits 30, 27, 26 and 25 are writable. Bit 7 is read-only and always reflects `secureBoot`. All other control bits read 0.
- R5: Misc bit 4 is loopback. It is writable, and while it is 1 no word is accepted (`wordReady` is 0).
- R6: `wordReady` is 1 only under all of these conditions: program bit is 1, INIT is 1, bit 26 (port enable) is 1, bit 27 (partial-reconfiguration routing) is 1, loopback is 0, and fewer than IMAGE_WORDS words have been accepted since the last abort. A word is accepted when `wordValid` and `wordReady` are both 1 at a clock edge.
- R7: While bit 25 (slow rate) is 1, each accepted word holds `wordReady` at 0 for the next RATE_DIV-1 cycles.
- R8: Status bit 0 (done) and interrupt bit 2 are set in the cycle after a full image has been accepted and bit 27 reads 0. They are not set while bit 27 is still 1.
- R9: Writing interrupt-clear data with bit 2 set clears interrupt bit 2 on the next edge and leaves done unchanged.
- R10: While the program bit reads 0, the next edge clears done, interrupt bit 2 and the accepted-word count. A later load needs a full new image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secureBoot | input | 1 | Secure boot indicator, shown on control bit 7 |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 32 | Control register write data |
| miscWe | input | 1 | Misc register write strobe |
| miscWdata | input | 32 | Misc register write data |
| intClrWe | input | 1 | Interrupt clear strobe |
| intClrData | input | 32 | Write-one-to-clear mask for interrupt status |
| wordValid | input | 1 | A configuration word is offered |
| wordReady | output | 1 | The block accepts the offered word |
| ctrlRdata | output | 32 | Control register read value |
| miscRdata | output | 32 | Misc register read value |
| statusRdata | output | 32 | Status: bit 4 INIT, bit 0 done |
| intStsRdata | output | 32 | Interrupt status: bit 2 configuration complete |

## Verification
The bench builds the block with INIT_HI_DLY=5, INIT_LO_DLY=3, IMAGE_WORDS=8 and RATE_DIV=3. With unequal rise and fall latencies, a swap of the two delays shows up in the measured cycle counts. A fall latency longer than one cycle makes it possible to reverse the program bit before INIT falls. With a short image, the bench can run a fast load, a slow load, an aborted partial load and an image that is one word short, all in a few hundred cycles. With a rate divider of 3, the holdoff shows a gap of two cycles, which cannot be confused with a gap of one.

// File: rtl/cfgrst_pkg.sv
package cfgrst_pkg;
  localparam int REG_W = 32;

  // control register fields
  localparam int PROG_BIT   = 30;
  localparam int PR_BIT     = 27;
  localparam int PORT_BIT   = 26;
  localparam int SLOW_BIT   = 25;
  localparam int SECURE_BIT = 7;
  // misc register field
  localparam int LOOP_BIT   = 4;
  // status register fields
  localparam int INIT_BIT   = 4;
  localparam int DONE_BIT   = 0;
  // interrupt status field
  localparam int IRQ_DONE_BIT = 2;

  localparam logic [REG_W-1:0] CTRL_WR_MASK =
    (REG_W'(1) << PROG_BIT) | (REG_W'(1) << PR_BIT) |
    (REG_W'(1) << PORT_BIT) | (REG_W'(1) << SLOW_BIT);
  localparam logic [REG_W-1:0] MISC_WR_MASK = REG_W'(1) << LOOP_BIT;
  localparam logic [REG_W-1:0] IRQ_MASK     = REG_W'(1) << IRQ_DONE_BIT;

  // levels handed from control to datapath
  typedef struct packed {
    logic progHigh;
    logic initHigh;
    logic portEn;
    logic prRoute;
    logic slowRate;
    logic loopback;
  } ctlStrobes_t;
endpackage

// File: rtl/cfgrst_ctrl.sv
module cfgrst_ctrl
  import cfgrst_pkg::*;
#(
  parameter int INIT_HI_DLY = 4,
  parameter int INIT_LO_DLY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secureBoot,
  input  logic             ctrlWe,
  input  logic [REG_W-1:0] ctrlWdata,
  input  logic             miscWe,
  input  logic [REG_W-1:0] miscWdata,
  output logic [REG_W-1:0] ctrlRdata,
  output logic [REG_W-1:0] miscRdata,
  output ctlStrobes_t      strobes
);
  localparam int MAX_DLY = (INIT_HI_DLY > INIT_LO_DLY) ? INIT_HI_DLY : INIT_LO_DLY;
  localparam int CNT_W   = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(INIT_HI_DLY - 1);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(INIT_LO_DLY - 1);

  logic [REG_W-1:0] ctrlRegQ;
  logic [REG_W-1:0] miscRegQ;
  logic             initQ;
  logic [CNT_W-1:0] dlyCntQ;
  logic             progHigh;
  logic             settleDone;

  assign progHigh = ctrlRegQ[PROG_BIT];

  // software-visible registers, non-writable bits forced to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlRegQ <= '0;
      miscRegQ <= '0;
    end else begin
      if (ctrlWe) ctrlRegQ <= ctrlWdata & CTRL_WR_MASK;
      if (miscWe) miscRegQ <= miscWdata & MISC_WR_MASK;
    end
  end

  // INIT settles towards the program level after the latency of that direction;
  // a reversal before settling restarts the count from zero
  assign settleDone = (dlyCntQ == (progHigh ? HI_LAST : LO_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ   <= 1'b0;
      dlyCntQ <= '0;
    end else if (progHigh != initQ) begin
      if (settleDone) begin
        initQ   <= progHigh;
        dlyCntQ <= '0;
      end else begin
        dlyCntQ <= dlyCntQ + 1'b1;
      end
    end else begin
      dlyCntQ <= '0;
    end
  end

  always_comb begin
    ctrlRdata = ctrlRegQ | (REG_W'(secureBoot) << SECURE_BIT);
    miscRdata = miscRegQ;
    strobes.progHigh = progHigh;
    strobes.initHigh = initQ;
    strobes.portEn   = ctrlRegQ[PORT_BIT];
    strobes.prRoute  = ctrlRegQ[PR_BIT];
    strobes.slowRate = ctrlRegQ[SLOW_BIT];
    strobes.loopback = miscRegQ[LOOP_BIT];
  end
endmodule

// File: rtl/cfgrst_data.sv
module cfgrst_data
  import cfgrst_pkg::*;
#(
  parameter int IMAGE_WORDS = 16,
  parameter int RATE_DIV    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             wordValid,
  input  logic             intClrWe,
  input  logic [REG_W-1:0] intClrData,
  output logic             wordReady,
  output logic             doneQ,
  output logic             irqDoneQ
);
  localparam int WCNT_W = $clog2(IMAGE_WORDS + 1);
  localparam logic [WCNT_W-1:0] IMAGE_LAST = WCNT_W'(IMAGE_WORDS);

  logic [WCNT_W-1:0] wordCntQ;
  logic imageFull;
  logic loadOpen;
  logic rateOk;
  logic accept;
  logic handBack;
  logic irqClear;

  assign imageFull = (wordCntQ == IMAGE_LAST);
  assign loadOpen  = strobes.progHigh & strobes.initHigh & strobes.portEn &
                     strobes.prRoute & ~strobes.loopback & ~imageFull;
  assign wordReady = loadOpen & rateOk;
  assign accept    = wordValid & wordReady;
  assign handBack  = imageFull & ~strobes.prRoute & strobes.progHigh &
                     strobes.initHigh & ~doneQ;
  assign irqClear  = intClrWe & (|(intClrData & IRQ_MASK));

  // word counter, wiped whenever the program bit is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wordCntQ <= '0;
    else if (!strobes.progHigh) wordCntQ <= '0;
    else if (accept)           wordCntQ <= wordCntQ + 1'b1;
  end

  // rate limiter variant picked by the divider
  generate
    if (RATE_DIV > 1) begin : g_slow
      localparam int HOLD_W = $clog2(RATE_DIV);
      logic [HOLD_W-1:0] holdQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      holdQ <= '0;
        else if (!strobes.progHigh || !strobes.slowRate) holdQ <= '0;
        else if (accept)                                holdQ <= HOLD_W'(RATE_DIV - 1);
        else if (holdQ != '0)                           holdQ <= holdQ - 1'b1;
      end
      assign rateOk = ~strobes.slowRate | (holdQ == '0);
    end else begin : g_fast
      assign rateOk = 1'b1;
    end
  endgenerate

  // completion flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      irqDoneQ <= 1'b0;
    end else if (!strobes.progHigh) begin
      doneQ    <= 1'b0;
      irqDoneQ <= 1'b0;
    end else begin
      if (handBack) doneQ <= 1'b1;
      if (handBack)      irqDoneQ <= 1'b1;
      else if (irqClear) irqDoneQ <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgrst_seq.sv
module cfgrst_seq
  import cfgrst_pkg::*;
#(
  parameter int INIT_HI_DLY = 4,
  parameter int INIT_LO_DLY = 3,
  parameter int IMAGE_WORDS = 16,
  parameter int RATE_DIV    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secureBoot,
  input  logic        ctrlWe,
  input  logic [31:0] ctrlWdata,
  input  logic        miscWe,
  input  logic [31:0] miscWdata,
  input  logic        intClrWe,
  input  logic [31:0] intClrData,
  input  logic        wordValid,
  output logic        wordReady,
  output logic [31:0] ctrlRdata,
  output logic [31:0] miscRdata,
  output logic [31:0] statusRdata,
  output logic [31:0] intStsRdata
);
  ctlStrobes_t strobes;
  logic doneQ;
  logic irqDoneQ;

  cfgrst_ctrl #(
    .INIT_HI_DLY(INIT_HI_DLY),
    .INIT_LO_DLY(INIT_LO_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .secureBoot(secureBoot),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .miscWe(miscWe), .miscWdata(miscWdata),
    .ctrlRdata(ctrlRdata), .miscRdata(miscRdata),
    .strobes(strobes)
  );

  cfgrst_data #(
    .IMAGE_WORDS(IMAGE_WORDS),
    .RATE_DIV(RATE_DIV)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wordValid(wordValid), .intClrWe(intClrWe), .intClrData(intClrData),
    .wordReady(wordReady), .doneQ(doneQ), .irqDoneQ(irqDoneQ)
  );

  always_comb begin
    statusRdata = '0;
    statusRdata[INIT_BIT] = strobes.initHigh;
    statusRdata[DONE_BIT] = doneQ;
    intStsRdata = '0;
    intStsRdata[IRQ_DONE_BIT] = irqDoneQ;
  end
endmodule

// File: rtl/cfgrst_chk.sv
module cfgrst_chk #(
  parameter int RATE_DIV = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic        wordReady,
  input logic        intClrWe,
  input logic [31:0] intClrData,
  input logic [31:0] ctrlRdata,
  input logic [31:0] miscRdata,
  input logic [31:0] statusRdata,
  input logic [31:0] intStsRdata
);
  // R2
  init_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusRdata[4]) |-> $past(ctrlRdata[30]));

  // R3
  init_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusRdata[4]) |-> !$past(ctrlRdata[30]));

  // R6
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (ctrlRdata[30] && statusRdata[4] && ctrlRdata[27] &&
                   ctrlRdata[26] && !miscRdata[4]));

  // R7
  slow_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((RATE_DIV > 1) && $past(wordValid && wordReady) && ctrlRdata[25] &&
     $past(ctrlRdata[25])) |-> !wordReady);

  // R8
  done_handback_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusRdata[0]) |-> !$past(ctrlRdata[27]));

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intStsRdata[2]) |-> ($past(intClrWe && intClrData[2]) || !$past(ctrlRdata[30])));

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdata[30] |=> (!statusRdata[0] && !intStsRdata[2]));
endmodule

bind cfgrst_seq cfgrst_chk #(.RATE_DIV(RATE_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordReady(wordReady),
  .intClrWe(intClrWe), .intClrData(intClrData), .ctrlRdata(ctrlRdata),
  .miscRdata(miscRdata), .statusRdata(statusRdata), .intStsRdata(intStsRdata)
);

// File: tb/test_cfgrst_seq.sv
module test_cfgrst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HI  = 5;
  localparam int LO  = 3;
  localparam int IMG = 8;
  localparam int RDV = 3;
  localparam logic [31:0] PROG = 32'h4000_0000;
  localparam logic [31:0] PR   = 32'h0800_0000;
  localparam logic [31:0] PORT = 32'h0400_0000;
  localparam logic [31:0] SLOW = 32'h0200_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secureBoot = 1'b0;
  logic ctrlWe = 1'b0, miscWe = 1'b0, intClrWe = 1'b0, wordValid = 1'b0;
  logic [31:0] ctrlWdata = '0, miscWdata = '0, intClrData = '0;
  logic wordReady;
  logic [31:0] ctrlRdata, miscRdata, statusRdata, intStsRdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgrst_seq #(
    .INIT_HI_DLY(HI), .INIT_LO_DLY(LO), .IMAGE_WORDS(IMG), .RATE_DIV(RDV)
  ) i_cfgrst_seq (
    .clk(clk), .rstN(rstN), .secureBoot(secureBoot),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .miscWe(miscWe), .miscWdata(miscWdata),
    .intClrWe(intClrWe), .intClrData(intClrData),
    .wordValid(wordValid), .wordReady(wordReady),
    .ctrlRdata(ctrlRdata), .miscRdata(miscRdata),
    .statusRdata(statusRdata), .intStsRdata(intStsRdata)
  );

  // behavioural reference model
  bit mProg, mPr, mPort, mSlow, mLoop, mInit, mDone, mIrq;
  int mDly, mWords, mHold;

  function automatic bit mReady();
    return mInit && mProg && mPort && mPr && !mLoop && (mWords < IMG) &&
           (!mSlow || mHold == 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mProg = 0; mPr = 0; mPort = 0; mSlow = 0; mLoop = 0;
      mInit = 0; mDone = 0; mIrq = 0; mDly = 0; mWords = 0; mHold = 0;
    end else begin
      bit acc, hand;
      acc  = wordValid && mReady();
      hand = (mWords == IMG) && !mPr && !mDone && mInit && mProg;
      if (!mProg) begin
        mWords = 0; mHold = 0; mDone = 0; mIrq = 0;
      end else begin
        if (acc) mWords++;
        if (!mSlow) mHold = 0;
        else if (acc) mHold = RDV - 1;
        else if (mHold > 0) mHold--;
        if (hand) begin mDone = 1; mIrq = 1; end
        else if (intClrWe && intClrData[2]) mIrq = 0;
      end
      if (mProg != mInit) begin
        if (mDly == (mProg ? HI : LO) - 1) begin mInit = mProg; mDly = 0; end
        else mDly++;
      end else mDly = 0;
      if (ctrlWe) begin
        mProg = ctrlWdata[30]; mPr = ctrlWdata[27];
        mPort = ctrlWdata[26]; mSlow = ctrlWdata[25];
      end
      if (miscWe) mLoop = miscWdata[4];
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      cmp("R4 ctrl", ctrlRdata, (32'(mProg) << 30) | (32'(mPr) << 27) |
          (32'(mPort) << 26) | (32'(mSlow) << 25) | (32'(secureBoot) << 7));
      cmp("R5 misc", miscRdata, 32'(mLoop) << 4);
      cmp("R2 status", statusRdata, (32'(mInit) << 4) | 32'(mDone));
      cmp("R9 irq", intStsRdata, 32'(mIrq) << 2);
      cmp("R6 ready", 32'(wordReady), 32'(mReady()));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrCtrl(logic [31:0] d);
    ctrlWe = 1'b1; ctrlWdata = d; tick(1); ctrlWe = 1'b0;
  endtask

  task automatic wrMisc(logic [31:0] d);
    miscWe = 1'b1; miscWdata = d; tick(1); miscWe = 1'b0;
  endtask

  task automatic waitInit(output int n);
    n = 0;
    while (!statusRdata[4] && n < 50) begin tick(1); n++; end
  endtask

  task automatic feed(int n);
    wordValid = 1'b1; tick(n); wordValid = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    cmp("R1 ctrl", ctrlRdata, 32'h0);
    cmp("R1 status", statusRdata, 32'h0);
    cmp("R1 irq", intStsRdata, 32'h0);
    cmp("R1 ready", 32'(wordReady), 32'h0);

    // R2 rise latency
    wrCtrl(PROG);
    waitInit(n);
    cmp("R2 rise cycles", 32'(n), 32'(HI));

    // R3 short reversal leaves INIT high
    wrCtrl(32'h0);
    wrCtrl(PROG);
    tick(LO + 3);
    cmp("R3 reversal init", 32'(statusRdata[4]), 32'h1);

    // R3 fall latency then second rise
    wrCtrl(32'h0);
    n = 0;
    while (statusRdata[4] && n < 50) begin tick(1); n++; end
    cmp("R3 fall cycles", 32'(n), 32'(LO));
    wrCtrl(PROG);
    waitInit(n);
    cmp("R2 second rise cycles", 32'(n), 32'(HI));

    // R5 loopback blocks words
    wrCtrl(PROG | PR | PORT);
    wrMisc(32'h10);
    wordValid = 1'b1;
    tick(2);
    cmp("R5 loopback ready", 32'(wordReady), 32'h0);
    wrMisc(32'h0);
    tick(IMG + 2);
    wordValid = 1'b0;
    // R6 full image closes the port; R8 no done before handback
    cmp("R6 full ready", 32'(wordReady), 32'h0);
    cmp("R8 done before handback", 32'(statusRdata[0]), 32'h0);
    wrCtrl(PROG | PORT);
    cmp("R8 done same cycle", 32'(statusRdata[0]), 32'h0);
    tick(1);
    cmp("R8 done after handback", 32'(statusRdata[0]), 32'h1);
    cmp("R8 irq after handback", 32'(intStsRdata[2]), 32'h1);

    // R9 clear interrupt keeps done
    intClrWe = 1'b1; intClrData = 32'h4; tick(1); intClrWe = 1'b0; intClrData = '0;
    cmp("R9 irq cleared", 32'(intStsRdata[2]), 32'h0);
    cmp("R9 done kept", 32'(statusRdata[0]), 32'h1);

    // R10 abort
    wrCtrl(PR | PORT);
    tick(1);
    cmp("R10 done cleared", 32'(statusRdata[0]), 32'h0);

    // R7 slow rate spacing
    wrCtrl(PROG | PR | PORT | SLOW);
    waitInit(n);
    wordValid = 1'b1;
    cmp("R7 first ready", 32'(wordReady), 32'h1);
    tick(1);
    cmp("R7 gap one", 32'(wordReady), 32'h0);
    tick(1);
    cmp("R7 gap two", 32'(wordReady), 32'h0);
    tick(1);
    cmp("R7 ready again", 32'(wordReady), 32'h1);
    tick(IMG * RDV + 4);
    wordValid = 1'b0;
    wrCtrl(PROG | PORT | SLOW);
    tick(1);
    cmp("R8 slow load done", 32'(statusRdata[0]), 32'h1);

    // R10 abort mid-load needs a whole new image
    wrCtrl(32'h0);
    wrCtrl(PROG | PR | PORT);
    waitInit(n);
    feed(3);
    wrCtrl(PR | PORT);
    tick(LO + 1);
    wrCtrl(PROG | PR | PORT);
    waitInit(n);
    feed(IMG - 1);
    wrCtrl(PROG | PORT);
    tick(2);
    cmp("R10 short image no done", 32'(statusRdata[0]), 32'h0);
    wrCtrl(PROG | PR | PORT);
    feed(1);
    wrCtrl(PROG | PORT);
    tick(1);
    cmp("R10 full image done", 32'(statusRdata[0]), 32'h1);

    // R4 write mask and read-only secure bit
    wrCtrl(32'hFFFF_FFFF);
    cmp("R4 masked write", ctrlRdata, 32'h4E00_0000);
    secureBoot = 1'b1;
    tick(1);
    cmp("R4 secure bit", ctrlRdata, 32'h4E00_0080);
    wrCtrl(32'h0);
    cmp("R4 secure not writable", ctrlRdata, 32'h0000_0080);
    tick(2);
    finish_run();
  end
endmodule